// File: doc/BRIEF.md
# Nine-bit asynchronous serial transmitter

This block sends one asynchronous frame on a single serial line for each accepted write. A frame carries a low start bit, eight data bits starting with the least significant, a ninth bit, and a high stop bit: eleven bit periods in total. The ninth bit can come from one of two sources. The first is a software-set flag that hardware clears once each frame finishes, which suits address/data marking on a shared multiprocessor link. The second, available only in the parity-capable mode and when parity is switched on, is a generated even-parity bit.

Bit timing comes from an external baud tick. Each bit period spans a fixed number of ticks. A busy output covers the whole frame, including the full stop bit. A sticky transmit-done flag rises as the stop bit starts. Software lowers that flag with a clear pulse.

Top module: `ninebit_tx`

## Requirements
- R1: After reset the line is high, busy is 0, the done flag is 0 and the ninth-bit flag is 0.
- R2: An accepted frame drives, in order, 0 (start), wr_data bit 0 through bit 7, the ninth bit, then 1 (stop). Each bit holds for 16 baud ticks. The start bit appears on the line in the cycle after the write.
- R3: With mode3 = 0, or with mode3 = 1 and par_en = 0, the ninth bit equals the ninth-bit flag value held at the moment of the write.
- R4: With mode3 = 1 and par_en = 1, the ninth bit is the XOR of the eight data bits, so the nine bits together hold an even number of ones.
- R5: With mode3 = 0, par_en has no effect on the ninth bit.
- R6: The done flag rises at the clock edge that consumes the 160th tick after the write, which is where the stop bit begins. It is not set earlier.
- R7: Busy is 1 from the cycle after the write until the edge that consumes the 176th tick. At that edge busy falls and the line stays high.
- R8: A write while busy is 1 is ignored, and the frame in progress continues unchanged.
- R9: tb8_wr loads tb8_in into the ninth-bit flag. The flag is cleared when the stop bit ends. If a tb8_wr falls in that same cycle, the write wins.
- R10: The done flag stays set until ti_clr is pulsed, and a new write does not clear it. If ti_clr falls in the cycle that sets the flag, the set wins.
- R11: The ninth-bit source and value are captured at the write. Later changes to mode3, par_en or the ninth-bit flag do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe: load byte and start a frame when idle |
| wr_data | input | 8 | Data byte to send |
| tb8_wr | input | 1 | Load strobe for the ninth-bit flag |
| tb8_in | input | 1 | Value loaded into the ninth-bit flag |
| mode3 | input | 1 | 1 = parity-capable mode, 0 = flag-only ninth-bit mode |
| par_en | input | 1 | Parity enable, honoured only when mode3 = 1 |
| baud_tick | input | 1 | One-cycle baud timing pulse |
| ti_clr | input | 1 | Clears the transmit-done flag |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| ti | output | 1 | Sticky transmit-done flag |
| tb8 | output | 1 | Current ninth-bit flag value |

## Verification
Two pairs of events can land in the same cycle. The first pair is the start of the stop bit, which sets the done flag, and a software clear of that flag. The second pair is the end of the stop bit, which clears the ninth-bit flag, and a software load of that flag. The bench forces each collision by pulsing ti_clr together with the 160th tick, and tb8_wr with the 176th tick. It then expects the done flag to be set and the loaded flag value to survive. Around these, it sweeps every mode, parity and flag setting over a spread of bytes. It also injects writes and configuration changes in the middle of frames and checks that the line is unaffected.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    typedef enum logic {
        SRC_FLAG   = 1'b0,
        SRC_PARITY = 1'b1
    } ninth_src_e;

    typedef struct packed {
        logic ti;
        logic tb8;
    } flag_state_t;

endpackage

// File: rtl/nbt_bit_timer.sv
module nbt_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic bit_end
);
    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             end_c;

    always_comb begin
        cnt_d = cnt_q;
        end_c = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            if (cnt_q == CNT_LAST) begin
                cnt_d = '0;
                end_c = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bit_end = end_c;

    // R2: tick count never leaves its bit period
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R2: counter is idle at zero while no frame runs
    a_r2_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/nbt_ninth_sel.sv
module nbt_ninth_sel import nbt_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              mode3,
    input  logic              par_en,
    input  logic              tb8_flag,
    input  logic [DATA_W-1:0] data,
    output logic              ninth
);
    ninth_src_e src;
    logic       even_bit;

    always_comb begin
        even_bit = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            even_bit = even_bit ^ data[i];
        end
        src   = (mode3 && par_en) ? SRC_PARITY : SRC_FLAG;
        ninth = (src == SRC_PARITY) ? even_bit : tb8_flag;
    end

endmodule

// File: rtl/nbt_flag_regs.sv
module nbt_flag_regs import nbt_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_begin,
    input  logic frame_done,
    input  logic ti_clr,
    input  logic tb8_wr,
    input  logic tb8_in,
    output logic ti,
    output logic tb8
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_begin)  st_d.ti = 1'b1;
        else if (ti_clr) st_d.ti = 1'b0;
        if (tb8_wr)          st_d.tb8 = tb8_in;
        else if (frame_done) st_d.tb8 = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ti  = st_q.ti;
    assign tb8 = st_q.tb8;

    // R10: done flag is sticky until cleared
    a_r10_ti_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ti && !ti_clr) |=> st_q.ti);

    // R6: done flag only rises from the stop-bit start
    a_r6_ti_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ti) |-> $past(stop_begin));

    // R9: ninth-bit flag only rises through a software load of 1
    a_r9_tb8_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tb8) |-> $past(tb8_wr && tb8_in));

    // R9: frame end without a load leaves the flag low
    a_r9_tb8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !tb8_wr) |=> !st_q.tb8);

endmodule

// File: rtl/nbt_frame_ctrl.sv
module nbt_frame_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ninth,
    input  logic              bit_end,
    output logic              accept,
    output logic              busy,
    output logic              txd,
    output logic              stop_begin,
    output logic              frame_done
);
    localparam int SH_W     = DATA_W + 2;
    localparam int LAST_IDX = DATA_W + 2;
    localparam int IDX_W    = $clog2(LAST_IDX + 1);
    localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(LAST_IDX);
    localparam logic [IDX_W-1:0] IDX_NINE = IDX_W'(LAST_IDX - 1);

    typedef struct packed {
        logic             busy;
        logic             txd;
        logic [SH_W-1:0]  shreg;
        logic [IDX_W-1:0] idx;
    } frm_state_t;

    frm_state_t st_d, st_q;
    logic       acc_c, stop_c, done_c;

    always_comb begin
        st_d   = st_q;
        acc_c  = wr_en && !st_q.busy;
        stop_c = 1'b0;
        done_c = 1'b0;
        if (acc_c) begin
            st_d.busy  = 1'b1;
            st_d.txd   = 1'b0;
            st_d.shreg = {1'b1, ninth, wr_data};
            st_d.idx   = '0;
        end else if (st_q.busy && bit_end) begin
            if (st_q.idx == IDX_STOP) begin
                st_d.busy = 1'b0;
                st_d.txd  = 1'b1;
                st_d.idx  = '0;
                done_c    = 1'b1;
            end else begin
                st_d.txd   = st_q.shreg[0];
                st_d.shreg = {1'b1, st_q.shreg[SH_W-1:1]};
                st_d.idx   = st_q.idx + 1'b1;
                stop_c     = (st_q.idx == IDX_NINE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.txd   <= 1'b1;
            st_q.shreg <= '1;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept     = acc_c;
    assign busy       = st_q.busy;
    assign txd        = st_q.txd;
    assign stop_begin = stop_c;
    assign frame_done = done_c;

    // R2: every frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> !st_q.txd);

    // R8: between bit boundaries nothing moves, writes included
    a_r8_hold_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !bit_end) |=> ($stable(st_q.txd) && $stable(st_q.idx) && st_q.busy));

    // R2: bit index stays inside the frame
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_STOP);

endmodule

// File: rtl/ninebit_tx.sv
module ninebit_tx #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tb8_wr,
    input  logic              tb8_in,
    input  logic              mode3,
    input  logic              par_en,
    input  logic              baud_tick,
    input  logic              ti_clr,
    output logic              txd,
    output logic              busy,
    output logic              ti,
    output logic              tb8
);
    logic ninth_w, bit_end_w, accept_w, stop_w, done_w;
    logic busy_w, txd_w, ti_w, tb8_w;

    nbt_ninth_sel #(.DATA_W(DATA_W)) u_sel (
        .mode3    (mode3),
        .par_en   (par_en),
        .tb8_flag (tb8_w),
        .data     (wr_data),
        .ninth    (ninth_w)
    );

    nbt_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_w),
        .restart (accept_w),
        .tick    (baud_tick),
        .bit_end (bit_end_w)
    );

    nbt_frame_ctrl #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ninth      (ninth_w),
        .bit_end    (bit_end_w),
        .accept     (accept_w),
        .busy       (busy_w),
        .txd        (txd_w),
        .stop_begin (stop_w),
        .frame_done (done_w)
    );

    nbt_flag_regs u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_begin (stop_w),
        .frame_done (done_w),
        .ti_clr     (ti_clr),
        .tb8_wr     (tb8_wr),
        .tb8_in     (tb8_in),
        .ti         (ti_w),
        .tb8        (tb8_w)
    );

    assign txd  = txd_w;
    assign busy = busy_w;
    assign ti   = ti_w;
    assign tb8  = tb8_w;

    // R7: line is high whenever no frame runs
    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R6: done flag rises only while the stop bit is on the line
    a_r6_ti_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti) |-> (busy && txd));

    // R7: busy falls with the line high
    a_r7_end_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> txd);

endmodule

// File: tb/ninebit_tx_tb.sv
module ninebit_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tb8_wr = 1'b0;
    logic       tb8_in = 1'b0;
    logic       mode3 = 1'b0;
    logic       par_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ti_clr = 1'b0;
    logic       txd, busy, ti, tb8;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    ninebit_tx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tb8_wr(tb8_wr), .tb8_in(tb8_in), .mode3(mode3), .par_en(par_en),
        .baud_tick(baud_tick), .ti_clr(ti_clr),
        .txd(txd), .busy(busy), .ti(ti), .tb8(tb8)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One frame with all its checks
    task automatic run_frame(input logic [7:0] d, input logic m3, input logic pe,
                             input logic tv, input logic keep_ti, input logic mid,
                             input logic co_ti, input logic co_tb8);
        logic ninth, ti_before, exp_bit;
        @(negedge clk);
        mode3 = m3; par_en = pe; tb8_wr = 1'b1; tb8_in = tv; ti_clr = !keep_ti;
        @(negedge clk);
        tb8_wr = 1'b0; ti_clr = 1'b0;
        check(tb8 == tv, "R9 load", int'(tb8), int'(tv));
        ti_before = ti;
        ninth = (m3 && pe) ? ^d : tv;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(busy == 1'b1, "R7 busy after write", int'(busy), 1);
        check(txd == 1'b0, "R2 start bit", int'(txd), 0);
        check(ti == ti_before, "R10 write keeps ti", int'(ti), int'(ti_before));
        for (int t = 1; t <= 176; t++) begin
            baud_tick = 1'b1;
            if (t == 160 && co_ti) ti_clr = 1'b1;
            if (t == 176 && co_tb8) begin tb8_wr = 1'b1; tb8_in = 1'b1; end
            @(negedge clk);
            baud_tick = 1'b0; ti_clr = 1'b0; tb8_wr = 1'b0;
            if (t % 16 == 8) begin
                int k = t / 16;
                if (k == 0)      exp_bit = 1'b0;
                else if (k <= 8) exp_bit = d[k-1];
                else if (k == 9) exp_bit = ninth;
                else             exp_bit = 1'b1;
                if (k == 9)
                    check(txd == exp_bit, (m3 && pe) ? "R4 parity bit" :
                          (!m3 && pe) ? "R5 mode2 ignores parity" : "R3 flag bit",
                          int'(txd), int'(exp_bit));
                else if (k > 3 && mid)
                    check(txd == exp_bit, "R8 R11 frame unchanged", int'(txd), int'(exp_bit));
                else
                    check(txd == exp_bit, "R2 bit value", int'(txd), int'(exp_bit));
            end
            if (t == 159) check(ti == ti_before, "R6 ti not early", int'(ti), int'(ti_before));
            if (t == 160) check(ti == 1'b1, co_ti ? "R10 set beats clear" : "R6 ti at stop start",
                                int'(ti), 1);
            if (t == 175) check(busy == 1'b1, "R7 busy through stop", int'(busy), 1);
            if (t == 176) begin
                check(busy == 1'b0, "R7 busy falls", int'(busy), 0);
                check(txd == 1'b1, "R7 line high", int'(txd), 1);
                check(tb8 == co_tb8, co_tb8 ? "R9 write beats clear" : "R9 cleared at end",
                      int'(tb8), int'(co_tb8));
            end
            if (mid && t == 40) begin
                wr_en = 1'b1; wr_data = ~d; tb8_wr = 1'b1; tb8_in = !tv;
                par_en = !pe; mode3 = !m3;
            end
            @(negedge clk);
            wr_en = 1'b0; tb8_wr = 1'b0;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", int'(txd), 1);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(ti == 1'b0, "R1 ti", int'(ti), 0);
        check(tb8 == 1'b0, "R1 tb8", int'(tb8), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int k = 0; k < 12; k++) begin
                logic [7:0] d;
                if (k == 0)      d = 8'h00;
                else if (k == 1) d = 8'hFF;
                else             d = 8'((k * 37 + cfg * 11 + 5) & 255);
                run_frame(d, cfg[2], cfg[1], cfg[0], 1'b0, k[0], 1'b0, 1'b0);
            end
        end

        // Collisions: clear with set, load with end-of-frame clear
        run_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        // Flag left set by the collision feeds the next frame (R3)
        run_frame(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

        // R10: ti persisted through the last write; now clear it
        check(ti == 1'b1, "R10 ti held", int'(ti), 1);
        @(negedge clk);
        ti_clr = 1'b1;
        @(negedge clk);
        ti_clr = 1'b0;
        check(ti == 1'b0, "R10 ti cleared", int'(ti), 0);
        check(txd == 1'b1 && busy == 1'b0, "R7 idle after frames", int'(txd), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule